// File: doc/BRIEF.md
# Leaky-Bucket Error Rate Monitor

This block turns a stream of error events from a link or device into a three-level health grade for system software. Every error pulse raises an internal bucket by one, and a periodic decay tick drains it by one. The bucket therefore measures recent error density rather than a lifetime total. Two software-set thresholds split the bucket value into good, degraded and failed. The degraded grade gives software warning before a failure is declared.

Any rise in grade produces a one-cycle interrupt pulse. The failed grade holds until software acknowledges it. A separate severe-error input skips the averaging and forces the failed grade at the next edge. It is meant for faults that hardware cannot recover from.

All pins are plain control and status levels or pulses. No data flows through the block, so it has no valid/ready interface and no back-pressure.

Top module: `err_rate_monitor`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, the bucket is zero, `health_o` reads 2'b00 (good) and `alert_o` is low.
- R2: An error pulse alone adds one to the bucket, and a decay tick alone subtracts one. A tick with the bucket at zero leaves it at zero.
- R3: An error pulse alone with the bucket at its maximum (all ones, 65535 by default) leaves it at the maximum. It does not wrap.
- R4: An error pulse and a decay tick in the same cycle leave the bucket unchanged.
- R5: The grade encoding is 2'b10 failed, 2'b01 degraded and 2'b00 good. The bucket level is failed when the bucket is at or above `fail_lim_i`, degraded when it is at or above `warn_lim_i`, and good otherwise. The failed comparison takes precedence, and 2'b11 never appears.
- R6: `health_o` shows the level of the bucket value held during the previous cycle. It changes one edge after the bucket changes.
- R7: `alert_o` is high for exactly the cycle in which `health_o` first shows a higher code than in the cycle before. A drop in grade raises no alert.
- R8: Once `health_o` is failed, it stays failed until a cycle with `fail_ack_i` high. It then takes the bucket level, unless that level is still failed or a severe error arrives in the same cycle.
- R9: A severe-error pulse makes `health_o` failed at the next edge, whatever the bucket value. It raises `alert_o` if the grade was not already failed.
- R10: Decay ticks can lower the grade from degraded to good without any acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse_i | input | 1 | One recoverable error event this cycle |
| decay_tick_i | input | 1 | Drain the bucket by one this cycle |
| severe_i | input | 1 | Unrecoverable error, forces failed |
| fail_ack_i | input | 1 | Software acknowledge that releases a held failed grade |
| warn_lim_i | input | 16 | Degraded threshold |
| fail_lim_i | input | 16 | Failed threshold |
| health_o | output | 2 | Grade: 00 good, 01 degraded, 10 failed |
| alert_o | output | 1 | Interrupt pulse on a rise in grade |

## Verification
Two pairs of events can land on the same edge. An error pulse can coincide with a decay tick, and a severe pulse or a threshold-driven failure can coincide with a software acknowledge. The directed part holds an error and a tick together for ten cycles and expects the grade to stay put. It also drives an acknowledge while the bucket still sits above the failed threshold and expects the grade to stay failed. The random phase draws all four inputs independently every cycle, so these collisions recur many times. Each result is judged against a bench model that applies R2 to R9 in the order the requirements give.

// File: rtl/erm_pkg.sv
package erm_pkg;
  typedef enum logic [1:0] {
    HL_GOOD     = 2'b00,
    HL_DEGRADED = 2'b01,
    HL_FAILED   = 2'b10
  } health_e;
endpackage

// File: rtl/erm_bucket.sv
// Saturating up/down error bucket.
module erm_bucket #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_i,
  input  logic             down_i,
  output logic [CNT_W-1:0] level_o
);
  localparam logic [CNT_W-1:0] TOP = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_o <= '0;
    end else begin
      unique case ({up_i, down_i})
        2'b10:   if (level_o != TOP) level_o <= level_o + ONE;
        2'b01:   if (level_o != '0)  level_o <= level_o - ONE;
        default: level_o <= level_o;  // idle or cancelling pair
      endcase
    end
  end
endmodule

// File: rtl/erm_classify.sv
// Maps a bucket value onto a health level; the failed compare wins.
module erm_classify
  import erm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] level_i,
  input  logic [CNT_W-1:0] warn_lim_i,
  input  logic [CNT_W-1:0] fail_lim_i,
  output health_e          grade_o
);
  always_comb begin
    if (level_i >= fail_lim_i)      grade_o = HL_FAILED;
    else if (level_i >= warn_lim_i) grade_o = HL_DEGRADED;
    else                            grade_o = HL_GOOD;
  end
endmodule

// File: rtl/erm_status.sv
// Registered grade with failed hold, severe override and rise alert.
module erm_status
  import erm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  health_e grade_i,
  input  logic    severe_i,
  input  logic    ack_i,
  output health_e health_o,
  output logic    alert_o
);
  logic    hold_fail;
  health_e grade_nxt;

  always_comb begin
    hold_fail = (health_o == HL_FAILED) && !ack_i;
    if (severe_i || hold_fail) grade_nxt = HL_FAILED;
    else                       grade_nxt = grade_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      health_o <= HL_GOOD;
      alert_o  <= 1'b0;
    end else begin
      health_o <= grade_nxt;
      alert_o  <= (grade_nxt > health_o);
    end
  end
endmodule

// File: rtl/err_rate_monitor.sv
module err_rate_monitor
  import erm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_pulse_i,
  input  logic             decay_tick_i,
  input  logic             severe_i,
  input  logic             fail_ack_i,
  input  logic [CNT_W-1:0] warn_lim_i,
  input  logic [CNT_W-1:0] fail_lim_i,
  output logic [1:0]       health_o,
  output logic             alert_o
);
  logic [CNT_W-1:0] bucket_q;
  health_e          grade_w;
  health_e          health_w;

  erm_bucket #(.CNT_W(CNT_W)) bucket_i (
    .clk(clk), .rst_n(rst_n), .up_i(err_pulse_i), .down_i(decay_tick_i),
    .level_o(bucket_q)
  );

  erm_classify #(.CNT_W(CNT_W)) classify_i (
    .level_i(bucket_q), .warn_lim_i(warn_lim_i), .fail_lim_i(fail_lim_i),
    .grade_o(grade_w)
  );

  erm_status status_i (
    .clk(clk), .rst_n(rst_n), .grade_i(grade_w), .severe_i(severe_i),
    .ack_i(fail_ack_i), .health_o(health_w), .alert_o(alert_o)
  );

  assign health_o = health_w;
endmodule

// File: rtl/erm_checker.sv
module erm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_pulse_i,
  input logic             decay_tick_i,
  input logic             severe_i,
  input logic             fail_ack_i,
  input logic [1:0]       health_o,
  input logic             alert_o,
  input logic [CNT_W-1:0] bucket_q
);
  localparam logic [CNT_W-1:0] TOP = '1;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bucket_q == TOP && err_pulse_i && !decay_tick_i) |=> bucket_q == TOP); // R3
  AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bucket_q == '0 && decay_tick_i && !err_pulse_i) |=> bucket_q == '0); // R2
  AST_PAIR_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse_i && decay_tick_i) |=> $stable(bucket_q)); // R4
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    health_o != 2'b11); // R5
  AST_ALERT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_o) |-> health_o > $past(health_o)); // R7
  AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (health_o == 2'b10 && !fail_ack_i) |=> health_o == 2'b10); // R8
  AST_SEVERE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    severe_i |=> health_o == 2'b10); // R9
endmodule

bind err_rate_monitor erm_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .err_pulse_i(err_pulse_i),
  .decay_tick_i(decay_tick_i), .severe_i(severe_i), .fail_ack_i(fail_ack_i),
  .health_o(health_o), .alert_o(alert_o), .bucket_q(bucket_q)
);

// File: tb/err_rate_monitor_tb_top.sv
`timescale 1ns/1ps
module err_rate_monitor_tb_top;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err = 1'b0, tick = 1'b0, sev = 1'b0, ack = 1'b0;
  logic [W-1:0] warn_lim = 16'd3, fail_lim = 16'd5;
  logic [1:0] health;
  logic alert;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  int unsigned m_cnt;
  logic [1:0] m_hl;
  logic m_alert;

  always #2 clk = ~clk;

  err_rate_monitor #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .err_pulse_i(err), .decay_tick_i(tick),
    .severe_i(sev), .fail_ack_i(ack), .warn_lim_i(warn_lim),
    .fail_lim_i(fail_lim), .health_o(health), .alert_o(alert)
  );

  function automatic logic [1:0] level_of(int unsigned c, int unsigned wl, int unsigned fl);
    if (c >= fl) return 2'b10;
    if (c >= wl) return 2'b01;
    return 2'b00;
  endfunction

  function automatic int unsigned next_cnt(int unsigned c, logic e, logic t);
    if (e && !t && c != 65535) return c + 1;
    if (t && !e && c != 0) return c - 1;
    return c;
  endfunction

  task automatic check(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; err = 0; tick = 0; sev = 0; ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_hl = 2'b00; m_alert = 1'b0;
  endtask

  // one cycle: drive at negedge, model at posedge, optional check at next negedge
  task automatic step(logic e, logic t, logic s, logic a, bit chk);
    logic [1:0] lvl, nhl;
    err = e; tick = t; sev = s; ack = a;
    @(posedge clk);
    lvl = level_of(m_cnt, warn_lim, fail_lim);
    nhl = (s || (m_hl == 2'b10 && !a)) ? 2'b10 : lvl;
    m_alert = nhl > m_hl;
    m_hl = nhl;
    m_cnt = next_cnt(m_cnt, e, t);
    @(negedge clk);
    err = 0; tick = 0; sev = 0; ack = 0;
    if (chk) begin
      check("R5 grade", health, m_hl);
      check("R7 alert", alert, m_alert);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 health in reset", health, 0);
    check("R1 alert in reset", alert, 0);
    do_reset();
    check("R1 health after reset", health, 0);

    // R2/R6: three errors reach degraded one edge later
    step(1, 0, 0, 0, 1); step(1, 0, 0, 0, 1); step(1, 0, 0, 0, 1);
    check("R6 no change yet", health, 0);
    step(0, 0, 0, 0, 1);
    check("R2 degraded after 3 errors", health, 1);
    check("R7 alert on rise", alert, 1);
    step(0, 0, 0, 0, 1);
    check("R7 alert one cycle", alert, 0);
    // R10: decay drops to good, no alert
    step(0, 1, 0, 0, 1); step(0, 0, 0, 0, 1);
    check("R10 back to good", health, 0);
    check("R10 no alert on drop", alert, 0);
    // R2 floor: many ticks, then 3 errors must give degraded (not failed)
    for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 1);
    step(1, 0, 0, 0, 1); step(1, 0, 0, 0, 1); step(1, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    check("R2 floor at zero", health, 1);
    // R4: paired events cancel
    for (int i = 0; i < 10; i++) step(1, 1, 0, 0, 1);
    check("R4 pair cancels", health, 1);
    step(1, 0, 0, 0, 1); step(1, 0, 0, 0, 1); step(0, 0, 0, 0, 1);
    check("R5 failed at limit", health, 2);
    check("R7 alert to failed", alert, 1);
    // R8: ack while still above limit keeps failed
    step(0, 0, 0, 1, 1);
    check("R8 ack above limit", health, 2);
    for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 1);
    check("R8 held after drain", health, 2);
    step(0, 0, 0, 1, 1);
    check("R8 released by ack", health, 0);
    // R9: severe with empty bucket, and severe beats ack
    step(0, 0, 1, 0, 1);
    check("R9 severe forces failed", health, 2);
    check("R9 severe alert", alert, 1);
    step(0, 0, 1, 1, 1);
    check("R9 severe beats ack", health, 2);
    step(0, 0, 0, 1, 1);
    check("R8 ack after severe", health, 0);

    // R3: saturate
    warn_lim = 16'hFFFE; fail_lim = 16'hFFFF;
    for (int i = 0; i < 65540; i++) step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    check("R3 saturated failed", health, 2);
    step(0, 1, 0, 1, 1);
    step(0, 0, 0, 1, 1);
    check("R3 no wrap", health, 1);

    // random rounds
    for (int r = 0; r < 3; r++) begin
      do_reset();
      warn_lim = W'(3 + $urandom % 6);
      fail_lim = warn_lim + W'(2 + $urandom % 6);
      for (int i = 0; i < 4000; i++)
        step(($urandom % 10) < 4, ($urandom % 10) < 3,
             ($urandom % 200) == 0, ($urandom % 30) == 0, 1);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule